// File: doc/BRIEF.md
# Multi-Channel Pin Waveform Formatter and Response Checker

This block is the digital core of a set of tester channels. Each channel takes a per-cycle pin vector and turns it into a formatted drive waveform on its pin. The vector carries a drive level, an expected response level, a direction bit and a compare-enable bit. The channel combines that vector with a leading strobe and a trailing strobe from an external timing generator. When the pin is receiving, the channel also checks the device response at a sample strobe. Every channel has its own format, strobes and compare logic. Nothing is shared between channels except the cycle-start pulse that begins each tester cycle.

On the clock where `cyc_start` is high, each channel loads its vector fields and its 2-bit format code into shadow registers. Changes on those inputs at other times have no effect on the cycle that is running. After that load, the strobes are clock-synchronous pulses. The leading strobe places the drive level on the pin. The trailing strobe ends the pulse in the way the format selects. The sample strobe compares the pin input with the expected level, and the result appears one clock later. A per-channel sticky bit collects fails until it is cleared.

The formatter is a data path driven by the cycle clock. Its inputs and outputs are plain per-clock signals with no valid/ready handshake, because a test cycle cannot be stalled. Every input must be valid on each clock edge where it is used.

Top module: `pinfmt_array`

## Requirements
- R1: While `rst_n` is low, `pin_drive`, `pin_oe`, `cyc_fail` and `fail_sticky` are 0 for every channel, and each channel's loaded vector reads as receive with compare off.
- R2: Vector fields and format codes are loaded only on a clock with `cyc_start` high. Changing them at any other time leaves the waveform and the compare result of the running cycle unchanged.
- R3: Format code 0 (non-return): on a drive cycle, the leading strobe sets `pin_drive` to the drive level and `pin_oe` to 1. The trailing strobe is ignored, and the level holds into later cycles until a later leading strobe.
- R4: Format code 1 (return-low): the leading strobe drives the level with `pin_oe` at 1, and the trailing strobe sets `pin_drive` to 0.
- R5: Format code 2 (return-high): the leading strobe drives the level with `pin_oe` at 1, and the trailing strobe sets `pin_drive` to 1.
- R6: Format code 3 (return-to-off): the leading strobe drives the level and sets `pin_oe` to 1, and the trailing strobe sets `pin_oe` to 0.
- R7: A vector with direction bit 0 (receive) sets `pin_oe` to 0 from the clock after `cyc_start` for the rest of that cycle. Both strobes and the format code have no effect on the pin during that cycle.
- R8: One clock after a sample strobe, `cyc_fail` is 1 only if the cycle is a receive cycle (direction 0), its compare-enable bit is 1 and `pin_in` differs from the expected level. `cyc_fail` then holds until the next `cyc_start` clock, which clears it.
- R9: A cycle with compare-enable 0, or with direction 1 (drive), never raises `cyc_fail`, whatever `pin_in` is.
- R10: `fail_sticky` is set in the same clock as any fail and stays set across cycles. A clock with `fail_clr` high clears it, and the clear wins over a fail in the same clock.
- R11: Channels are independent: each channel uses its own format code, strobes, vector and pin input.
- R12: On a clock with no `cyc_start`, no leading strobe and no trailing strobe for a channel, that channel's `pin_drive` and `pin_oe` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tester clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_start | input | 1 | Shared cycle-start pulse; loads vectors and formats |
| vec_level | input | NUM_CH | Drive level per channel |
| vec_exp | input | NUM_CH | Expected response level per channel |
| vec_dir | input | NUM_CH | 1 = drive, 0 = receive |
| vec_cmp | input | NUM_CH | 1 = a compare miss counts as a fail |
| fmt_sel | input | 2*NUM_CH | Format code per channel: 0 non-return, 1 return-low, 2 return-high, 3 return-to-off |
| lead_stb | input | NUM_CH | Leading timing strobe per channel |
| trail_stb | input | NUM_CH | Trailing timing strobe per channel |
| sample_stb | input | NUM_CH | Response sample strobe per channel |
| pin_in | input | NUM_CH | Sensed device response per channel |
| fail_clr | input | 1 | Synchronous clear of all sticky fail bits |
| pin_drive | output | NUM_CH | Formatted drive value per channel |
| pin_oe | output | NUM_CH | Drive enable per channel |
| cyc_fail | output | NUM_CH | Per-cycle fail flag per channel |
| fail_sticky | output | NUM_CH | Accumulated fail per channel |

## Verification
The assertions assume that `cyc_start` never arrives on the same clock as a leading, trailing or sample strobe. They also assume that each leading strobe comes before its trailing strobe in the same cycle, and that `pin_in` is settled at the sample clock. The stimulus gives each event its own clock: a start, then lead with sample, then trail. Vector and format inputs change only on negative clock edges, and a separate test changes them in the middle of a cycle to confirm that the running cycle keeps the values loaded at its start.

// File: rtl/pinfmt_pkg.sv
package pinfmt_pkg;
  typedef enum logic [1:0] {
    FMT_NRZ = 2'd0,
    FMT_RLO = 2'd1,
    FMT_RHI = 2'd2,
    FMT_ROFF = 2'd3
  } fmt_e;

  typedef struct packed {
    logic lvl;
    logic exp_lvl;
    logic drive_en;
    logic cmp_en;
  } pinvec_t;

  localparam int FMT_W = 2;
endpackage

// File: rtl/pinfmt_latch.sv
module pinfmt_latch
  import pinfmt_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    load,
  input  pinvec_t vec_in,
  input  fmt_e    fmt_in,
  output pinvec_t vec_q,
  output fmt_e    fmt_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q <= '0;
      fmt_q <= FMT_NRZ;
    end else if (load) begin
      vec_q <= vec_in;
      fmt_q <= fmt_in;
    end
  end
endmodule

// File: rtl/pinfmt_wave.sv
module pinfmt_wave
  import pinfmt_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    load,
  input  logic    next_drive,
  input  pinvec_t vec_q,
  input  fmt_e    fmt_q,
  input  logic    lead,
  input  logic    trail,
  output logic    drv,
  output logic    oe
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv <= 1'b0;
      oe  <= 1'b0;
    end else if (load) begin
      if (!next_drive) oe <= 1'b0;
    end else if (vec_q.drive_en) begin
      if (lead) begin
        drv <= vec_q.lvl;
        oe  <= 1'b1;
      end else if (trail) begin
        unique case (fmt_q)
          FMT_NRZ:  ;
          FMT_RLO:  drv <= 1'b0;
          FMT_RHI:  drv <= 1'b1;
          FMT_ROFF: oe  <= 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/pinfmt_cmp.sv
module pinfmt_cmp
  import pinfmt_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    load,
  input  logic    sample,
  input  logic    pin_in,
  input  logic    clr,
  input  pinvec_t vec_q,
  output logic    fail,
  output logic    sticky
);
  logic miss;

  assign miss = sample && !vec_q.drive_en && vec_q.cmp_en && (pin_in != vec_q.exp_lvl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail   <= 1'b0;
      sticky <= 1'b0;
    end else begin
      if (sample)    fail <= miss;
      else if (load) fail <= 1'b0;
      if (clr)       sticky <= 1'b0;
      else if (miss) sticky <= 1'b1;
    end
  end
endmodule

// File: rtl/pinfmt_array.sv
module pinfmt_array
  import pinfmt_pkg::*;
#(
  parameter int NUM_CH = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cyc_start,
  input  logic [NUM_CH-1:0]     vec_level,
  input  logic [NUM_CH-1:0]     vec_exp,
  input  logic [NUM_CH-1:0]     vec_dir,
  input  logic [NUM_CH-1:0]     vec_cmp,
  input  logic [2*NUM_CH-1:0]   fmt_sel,
  input  logic [NUM_CH-1:0]     lead_stb,
  input  logic [NUM_CH-1:0]     trail_stb,
  input  logic [NUM_CH-1:0]     sample_stb,
  input  logic [NUM_CH-1:0]     pin_in,
  input  logic                  fail_clr,
  output logic [NUM_CH-1:0]     pin_drive,
  output logic [NUM_CH-1:0]     pin_oe,
  output logic [NUM_CH-1:0]     cyc_fail,
  output logic [NUM_CH-1:0]     fail_sticky
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pinvec_t vin, vq;
    fmt_e    fin, fq;

    assign vin = '{lvl: vec_level[c], exp_lvl: vec_exp[c], drive_en: vec_dir[c], cmp_en: vec_cmp[c]};
    assign fin = fmt_e'(fmt_sel[FMT_W*c +: FMT_W]);

    pinfmt_latch u_latch (
      .clk(clk), .rst_n(rst_n), .load(cyc_start),
      .vec_in(vin), .fmt_in(fin), .vec_q(vq), .fmt_q(fq)
    );

    pinfmt_wave u_wave (
      .clk(clk), .rst_n(rst_n), .load(cyc_start), .next_drive(vec_dir[c]),
      .vec_q(vq), .fmt_q(fq), .lead(lead_stb[c]), .trail(trail_stb[c]),
      .drv(pin_drive[c]), .oe(pin_oe[c])
    );

    pinfmt_cmp u_cmp (
      .clk(clk), .rst_n(rst_n), .load(cyc_start), .sample(sample_stb[c]),
      .pin_in(pin_in[c]), .clr(fail_clr), .vec_q(vq),
      .fail(cyc_fail[c]), .sticky(fail_sticky[c])
    );
  end
endmodule

// File: rtl/pinfmt_array_chk.sv
module pinfmt_array_chk #(
  parameter int NUM_CH = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cyc_start,
  input logic [NUM_CH-1:0] vec_dir,
  input logic [NUM_CH-1:0] lead_stb,
  input logic [NUM_CH-1:0] trail_stb,
  input logic [NUM_CH-1:0] sample_stb,
  input logic              fail_clr,
  input logic [NUM_CH-1:0] pin_drive,
  input logic [NUM_CH-1:0] pin_oe,
  input logic [NUM_CH-1:0] cyc_fail,
  input logic [NUM_CH-1:0] fail_sticky
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_a
    assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |=> (!pin_oe[c] && !cyc_fail[c] && !fail_sticky[c]));

    assert_receive_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_start && !vec_dir[c]) |=> !pin_oe[c]);

    assert_fail_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!sample_stb[c] && !cyc_start) |=> $stable(cyc_fail[c]));

    assert_sticky_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      fail_clr |=> !fail_sticky[c]);

    assert_sticky_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!fail_clr && fail_sticky[c]) |=> fail_sticky[c]);

    assert_pin_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!cyc_start && !lead_stb[c] && !trail_stb[c]) |=> ($stable(pin_oe[c]) && $stable(pin_drive[c])));
  end
endmodule

bind pinfmt_array pinfmt_array_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .vec_dir(vec_dir),
  .lead_stb(lead_stb), .trail_stb(trail_stb), .sample_stb(sample_stb),
  .fail_clr(fail_clr), .pin_drive(pin_drive), .pin_oe(pin_oe),
  .cyc_fail(cyc_fail), .fail_sticky(fail_sticky)
);

// File: tb/pinfmt_array_bench.sv
module pinfmt_array_bench;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc_start = 1'b0;
  logic fail_clr = 1'b0;
  logic [N-1:0] vec_level = '0, vec_exp = '0, vec_dir = '0, vec_cmp = '0;
  logic [2*N-1:0] fmt_sel = '0;
  logic [N-1:0] lead_stb = '0, trail_stb = '0, sample_stb = '0, pin_in = '0;
  logic [N-1:0] pin_drive, pin_oe, cyc_fail, fail_sticky;

  int checks = 0;
  int errs = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pinfmt_array #(.NUM_CH(N)) u_pinfmt_array (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start),
    .vec_level(vec_level), .vec_exp(vec_exp), .vec_dir(vec_dir), .vec_cmp(vec_cmp),
    .fmt_sel(fmt_sel), .lead_stb(lead_stb), .trail_stb(trail_stb),
    .sample_stb(sample_stb), .pin_in(pin_in), .fail_clr(fail_clr),
    .pin_drive(pin_drive), .pin_oe(pin_oe), .cyc_fail(cyc_fail), .fail_sticky(fail_sticky)
  );

  // Row: [13:12] fmt, [11] level, [10] exp, [9] dir, [8] cmp, [7] pin,
  //      [6] drv after lead, [5] oe after lead, [4] drv after trail,
  //      [3] oe after trail, [2] fail, [1] check drv, [0] unused
  localparam int ROWS = 11;
  localparam logic [13:0] TBL [ROWS] = '{
    14'b00_1_0_1_0_0_1_1_1_1_0_1_0, // R3 non-return high
    14'b00_0_0_1_0_0_0_1_0_1_0_1_0, // R3 non-return low
    14'b01_1_0_1_0_0_1_1_0_1_0_1_0, // R4 return-low
    14'b10_0_0_1_0_0_0_1_1_1_0_1_0, // R5 return-high
    14'b11_1_0_1_0_0_1_1_1_0_0_1_0, // R6 return-to-off
    14'b01_0_0_1_0_0_0_1_0_1_0_1_0, // R4 low level stays low
    14'b10_0_1_0_1_0_0_0_0_0_1_0_0, // R7 R8 receive miss
    14'b01_0_1_0_1_1_0_0_0_0_0_0_0, // R8 receive match
    14'b00_0_0_0_0_1_0_0_0_0_0_0_0, // R9 compare disabled
    14'b00_1_0_1_1_1_1_1_1_1_0_1_0, // R9 drive cycle never fails
    14'b11_0_0_0_1_1_0_0_0_0_1_0_0  // R8 receive miss, expected 0
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic load_ch(input int ch, input logic [1:0] f, input logic lv, input logic ex,
                         input logic dr, input logic cm);
    vec_level[ch] = lv; vec_exp[ch] = ex; vec_dir[ch] = dr; vec_cmp[ch] = cm;
    fmt_sel[2*ch +: 2] = f;
  endtask

  task automatic run_row(input int i);
    logic [13:0] r;
    r = TBL[i];
    @(negedge clk);
    load_ch(0, r[13:12], r[11], r[10], r[9], r[8]);
    pin_in[0] = r[7];
    cyc_start = 1'b1;
    @(negedge clk);
    cyc_start = 1'b0; lead_stb[0] = 1'b1; sample_stb[0] = 1'b1;
    @(negedge clk);
    lead_stb[0] = 1'b0; sample_stb[0] = 1'b0;
    if (r[1]) chk($sformatf("R3-6 row%0d lead drv", i), pin_drive[0], r[6]);
    chk($sformatf("R7 row%0d lead oe", i), pin_oe[0], r[5]);
    chk($sformatf("R8 row%0d fail", i), cyc_fail[0], r[2]);
    trail_stb[0] = 1'b1;
    @(negedge clk);
    trail_stb[0] = 1'b0;
    if (r[1]) chk($sformatf("R3-6 row%0d trail drv", i), pin_drive[0], r[4]);
    chk($sformatf("R6 row%0d trail oe", i), pin_oe[0], r[3]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset oe", pin_oe[0], 1'b0);
    chk("R1 reset drv", pin_drive[0], 1'b0);
    chk("R1 reset fail", cyc_fail[0], 1'b0);
    chk("R1 reset sticky", fail_sticky[0], 1'b0);
    rst_n = 1'b1;

    for (int i = 0; i < ROWS; i++) run_row(i);
    chk("R10 sticky collected", fail_sticky[0], 1'b1);

    // R8: a new cycle start clears the per-cycle flag
    @(negedge clk);
    load_ch(0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    cyc_start = 1'b1;
    @(negedge clk);
    cyc_start = 1'b0;
    chk("R8 fail cleared at start", cyc_fail[0], 1'b0);
    chk("R10 sticky survives start", fail_sticky[0], 1'b1);

    // R10: clear
    fail_clr = 1'b1;
    @(negedge clk);
    fail_clr = 1'b0;
    chk("R10 sticky cleared", fail_sticky[0], 1'b0);

    // R2: inputs changed mid-cycle are not taken
    @(negedge clk);
    load_ch(0, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0);
    cyc_start = 1'b1;
    @(negedge clk);
    cyc_start = 1'b0;
    load_ch(0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    lead_stb[0] = 1'b1;
    @(negedge clk);
    lead_stb[0] = 1'b0;
    chk("R2 level from start", pin_drive[0], 1'b1);
    chk("R2 oe from start", pin_oe[0], 1'b1);
    trail_stb[0] = 1'b1;
    @(negedge clk);
    trail_stb[0] = 1'b0;
    chk("R2 format from start", pin_drive[0], 1'b1);

    // R12: outputs hold without events
    repeat (3) @(negedge clk);
    chk("R12 drv held", pin_drive[0], 1'b1);
    chk("R12 oe held", pin_oe[0], 1'b1);

    // R11: two channels with different formats in the same cycle
    @(negedge clk);
    load_ch(0, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0);
    load_ch(3, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0);
    cyc_start = 1'b1;
    @(negedge clk);
    cyc_start = 1'b0; lead_stb[0] = 1'b1; lead_stb[3] = 1'b1;
    @(negedge clk);
    lead_stb = '0;
    chk("R11 ch0 lead", pin_drive[0], 1'b1);
    chk("R11 ch3 lead", pin_drive[3], 1'b0);
    chk("R11 ch5 idle oe", pin_oe[5], 1'b0);
    trail_stb[0] = 1'b1; trail_stb[3] = 1'b1;
    @(negedge clk);
    trail_stb = '0;
    chk("R11 ch0 trail", pin_drive[0], 1'b0);
    chk("R11 ch3 trail", pin_drive[3], 1'b1);

    // R7: strobes on a receive cycle leave the pin off
    @(negedge clk);
    load_ch(3, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0);
    cyc_start = 1'b1;
    @(negedge clk);
    cyc_start = 1'b0;
    chk("R7 oe off after start", pin_oe[3], 1'b0);
    lead_stb[3] = 1'b1;
    @(negedge clk);
    lead_stb[3] = 1'b0;
    chk("R7 lead ignored", pin_oe[3], 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule